// File: doc/BRIEF.md
# Boot Region Remap Decoder

This block is the address decoder for a multi-master crossbar whose lowest megabyte of address space, the boot region, can be backed by one of three slaves. While reset is held, the block samples a boot-select input. A low value backs the boot region with internal ROM. A high value backs it with the external memory on chip-select 0. Later, software can issue a remap command that puts internal SRAM in the boot region, so that exception vectors can be rewritten at run time. A clear command returns the region to its boot-time target.

Every master decodes addresses the same way. The block therefore holds one shared boot and remap state, and replicates a single decoder definition once per master port. Each port takes a valid bit and an address and returns a one-hot slave select. The fixed windows for ROM, SRAM, external chip-select 0 and peripherals always decode to their own slaves. An address that falls in no window selects an error slave.

Top module: `boot_remap_decoder`

## Requirements
- R1: The boot-select input is sampled on every clock edge while reset is low. Once reset is released, the boot target stays fixed whatever the input does.
- R2: The select vector uses this bit order: bit 0 ROM, bit 1 external chip-select 0, bit 2 SRAM, bit 3 peripherals, bit 4 error. With remap inactive and the boot bit sampled as 0, any address from 0x0000_0000 to 0x000F_FFFF selects ROM (bit 0).
- R3: With remap inactive and the boot bit sampled as 1, the boot region selects external chip-select 0 (bit 1).
- R4: A one-cycle pulse on the remap-set input makes the boot region select SRAM (bit 2) from the next cycle on. This lasts until a clear or a reset.
- R5: A pulse on the remap-clear input returns the boot region to its boot-time target from the next cycle on. When set and clear arrive in the same cycle, clear wins.
- R6: The fixed windows decode the same way whatever the remap and boot state: 0x0010_0000 to 0x001F_FFFF selects ROM, 0x0030_0000 to 0x003F_FFFF selects SRAM, 0x1000_0000 to 0x1FFF_FFFF selects chip-select 0, and 0xF000_0000 to 0xFFFF_FFFF selects peripherals.
- R7: An address in no window selects the error slave (bit 4).
- R8: When a port's valid bit is low, all select bits of that port are 0. When it is high, exactly one bit is set.
- R9: Every port decodes its own address at the same time, using the same map and the shared boot and remap state.
- R10: Reset clears the remap state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_ext_i | input | 1 | Boot-select input, sampled while reset is low |
| remap_set_i | input | 1 | One-cycle remap command |
| remap_clr_i | input | 1 | One-cycle remap undo command |
| req_valid_i | input | NUM_PORTS | Per-master request valid |
| req_addr_i | input | NUM_PORTS*ADDR_W | Per-master address, port p in slice p |
| sel_o | output | NUM_PORTS*5 | Per-master one-hot slave select, port p in slice p |

## Verification
The hardest case to reach is a boot target that differs from the boot-select input's current level. The port only shows the sampled value. The bench therefore holds the input at one level through reset, then drives the opposite level for many cycles and probes the boot region. It also issues set and clear in the same cycle, and it resets while remap is active, to show that the shared state returns to its boot-time target on every port.

// File: rtl/brd_pkg.sv
package brd_pkg;
   // slave index within each port's select vector
   localparam int SLV_ROM    = 0;
   localparam int SLV_EXT0   = 1;
   localparam int SLV_SRAM   = 2;
   localparam int SLV_PERIPH = 3;
   localparam int SLV_ERR    = 4;
   localparam int NSLV       = 5;

   typedef logic [NSLV-1:0] sel_t;

   function automatic sel_t slv_bit(input int idx);
      sel_t s;
      s = '0;
      s[idx] = 1'b1;
      return s;
   endfunction
endpackage

// File: rtl/brd_boot_state.sv
module brd_boot_state (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_ext_i,
   input  logic remap_set_i,
   input  logic remap_clr_i,
   output logic boot_ext_q,
   output logic remap_q
);
   // boot pin is captured on each edge while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         boot_ext_q <= boot_ext_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remap_q <= 1'b0;
      end else if (remap_clr_i) begin
         remap_q <= 1'b0;
      end else if (remap_set_i) begin
         remap_q <= 1'b1;
      end
   end
endmodule

// File: rtl/brd_addr_decode.sv
module brd_addr_decode
   import brd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BOOT_LOG2 = 20,
   parameter logic [ADDR_W-1:0] ROMW_BASE = 'h0010_0000,
   parameter int ROMW_LOG2 = 20,
   parameter logic [ADDR_W-1:0] SRAMW_BASE = 'h0030_0000,
   parameter int SRAMW_LOG2 = 20,
   parameter logic [ADDR_W-1:0] EXTW_BASE = 'h1000_0000,
   parameter int EXTW_LOG2 = 28,
   parameter logic [ADDR_W-1:0] PERW_BASE = 'hF000_0000,
   parameter int PERW_LOG2 = 28
) (
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              boot_ext_i,
   input  logic              remap_i,
   output sel_t              sel_o
);
   localparam logic [ADDR_W-1:0] BOOT_BASE = '0;

   function automatic logic hit(input logic [ADDR_W-1:0] a,
                                input logic [ADDR_W-1:0] base,
                                input int lg);
      return (a >> lg) == (base >> lg);
   endfunction

   logic in_boot, in_rom, in_sram, in_ext, in_per;

   always_comb begin
      in_boot = hit(addr_i, BOOT_BASE, BOOT_LOG2);
      in_rom  = hit(addr_i, ROMW_BASE, ROMW_LOG2);
      in_sram = hit(addr_i, SRAMW_BASE, SRAMW_LOG2);
      in_ext  = hit(addr_i, EXTW_BASE, EXTW_LOG2);
      in_per  = hit(addr_i, PERW_BASE, PERW_LOG2);
   end

   always_comb begin
      sel_o = '0;
      if (valid_i) begin
         if (in_boot) begin
            if (remap_i)         sel_o = slv_bit(SLV_SRAM);
            else if (boot_ext_i) sel_o = slv_bit(SLV_EXT0);
            else                 sel_o = slv_bit(SLV_ROM);
         end else if (in_rom)  sel_o = slv_bit(SLV_ROM);
         else if (in_sram)     sel_o = slv_bit(SLV_SRAM);
         else if (in_ext)      sel_o = slv_bit(SLV_EXT0);
         else if (in_per)      sel_o = slv_bit(SLV_PERIPH);
         else                  sel_o = slv_bit(SLV_ERR);
      end
   end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
   import brd_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int ADDR_W    = 32,
   parameter int BOOT_LOG2 = 20,
   parameter bit OUT_REG   = 1'b0,
   parameter logic [ADDR_W-1:0] ROMW_BASE = 'h0010_0000,
   parameter int ROMW_LOG2 = 20,
   parameter logic [ADDR_W-1:0] SRAMW_BASE = 'h0030_0000,
   parameter int SRAMW_LOG2 = 20,
   parameter logic [ADDR_W-1:0] EXTW_BASE = 'h1000_0000,
   parameter int EXTW_LOG2 = 28,
   parameter logic [ADDR_W-1:0] PERW_BASE = 'hF000_0000,
   parameter int PERW_LOG2 = 28
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          boot_ext_i,
   input  logic                          remap_set_i,
   input  logic                          remap_clr_i,
   input  logic [NUM_PORTS-1:0]          req_valid_i,
   input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr_i,
   output logic [NUM_PORTS*NSLV-1:0]     sel_o
);
   localparam int SEL_W = NUM_PORTS * NSLV;

   // elaboration-time parameter checks
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end
   if (BOOT_LOG2 < 1 || BOOT_LOG2 >= ADDR_W) begin : g_bad_boot
      $error("BOOT_LOG2 out of range");
   end
   if ((ROMW_BASE & ((ADDR_W'(1) << ROMW_LOG2) - 1)) != 0) begin : g_bad_rom
      $error("ROM window base not aligned");
   end
   if ((SRAMW_BASE & ((ADDR_W'(1) << SRAMW_LOG2) - 1)) != 0) begin : g_bad_sram
      $error("SRAM window base not aligned");
   end
   if ((EXTW_BASE & ((ADDR_W'(1) << EXTW_LOG2) - 1)) != 0) begin : g_bad_ext
      $error("external window base not aligned");
   end
   if ((PERW_BASE & ((ADDR_W'(1) << PERW_LOG2) - 1)) != 0) begin : g_bad_per
      $error("peripheral window base not aligned");
   end

   logic boot_q;
   logic remap_q;

   brd_boot_state u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .boot_ext_i (boot_ext_i),
      .remap_set_i(remap_set_i),
      .remap_clr_i(remap_clr_i),
      .boot_ext_q (boot_q),
      .remap_q    (remap_q)
   );

   logic [SEL_W-1:0] sel_d;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      brd_addr_decode #(
         .ADDR_W    (ADDR_W),
         .BOOT_LOG2 (BOOT_LOG2),
         .ROMW_BASE (ROMW_BASE),
         .ROMW_LOG2 (ROMW_LOG2),
         .SRAMW_BASE(SRAMW_BASE),
         .SRAMW_LOG2(SRAMW_LOG2),
         .EXTW_BASE (EXTW_BASE),
         .EXTW_LOG2 (EXTW_LOG2),
         .PERW_BASE (PERW_BASE),
         .PERW_LOG2 (PERW_LOG2)
      ) u_dec (
         .valid_i   (req_valid_i[p]),
         .addr_i    (req_addr_i[p*ADDR_W +: ADDR_W]),
         .boot_ext_i(boot_q),
         .remap_i   (remap_q),
         .sel_o     (sel_d[p*NSLV +: NSLV])
      );
   end

   if (OUT_REG) begin : g_reg_out
      logic [SEL_W-1:0] sel_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sel_q <= '0;
         else        sel_q <= sel_d;
      end
      assign sel_o = sel_q;
   end else begin : g_comb_out
      assign sel_o = sel_d;
   end
endmodule

module brd_chk
   import brd_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int ADDR_W    = 32,
   parameter int BOOT_LOG2 = 20,
   parameter bit OUT_REG   = 1'b0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        remap_set_i,
   input logic                        remap_clr_i,
   input logic                        boot_q,
   input logic                        remap_q,
   input logic [NUM_PORTS-1:0]        req_valid_i,
   input logic [NUM_PORTS*ADDR_W-1:0] req_addr_i,
   input logic [NUM_PORTS*NSLV-1:0]   sel_o
);
   // R1
   boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(boot_q));
   // R4
   remap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_set_i && !remap_clr_i) |=> remap_q);
   // R5
   remap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remap_clr_i |=> !remap_q);
   // R4
   remap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!remap_set_i && !remap_clr_i) |=> $stable(remap_q));
   // R10
   remap_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !remap_q);

   if (!OUT_REG) begin : g_comb_chk
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
         // R8
         idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid_i[p] |-> (sel_o[p*NSLV +: NSLV] == '0));
         // R8
         one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid_i[p] |-> $onehot(sel_o[p*NSLV +: NSLV]));
         // R4
         boot_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid_i[p] && remap_q &&
             (req_addr_i[p*ADDR_W+BOOT_LOG2 +: ADDR_W-BOOT_LOG2] == '0))
            |-> sel_o[p*NSLV+SLV_SRAM]);
      end
   end
endmodule

bind boot_remap_decoder brd_chk #(
   .NUM_PORTS(NUM_PORTS),
   .ADDR_W   (ADDR_W),
   .BOOT_LOG2(BOOT_LOG2),
   .OUT_REG  (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .remap_set_i(remap_set_i),
   .remap_clr_i(remap_clr_i),
   .boot_q     (boot_q),
   .remap_q    (remap_q),
   .req_valid_i(req_valid_i),
   .req_addr_i (req_addr_i),
   .sel_o      (sel_o)
);

// File: tb/sim_boot_remap_decoder.sv
module sim_boot_remap_decoder;
   localparam int NP = 3;
   localparam int AW = 32;
   localparam int NS = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic boot_ext = 1'b0;
   logic rset = 1'b0;
   logic rclr = 1'b0;
   logic [NP-1:0] vld = '0;
   logic [NP*AW-1:0] addr = '0;
   logic [NP*NS-1:0] sel;

   int checks = 0;
   int fails = 0;
   bit boot_m = 1'b0;
   bit remap_m = 1'b0;

   always #5 clk = ~clk;

   boot_remap_decoder u0 (
      .clk(clk), .rst_n(rst_n), .boot_ext_i(boot_ext),
      .remap_set_i(rset), .remap_clr_i(rclr),
      .req_valid_i(vld), .req_addr_i(addr), .sel_o(sel)
   );

   // expected select from the documented map
   function automatic logic [NS-1:0] model(input logic [AW-1:0] a);
      if (a < 32'h0010_0000) return remap_m ? 5'b00100 : (boot_m ? 5'b00010 : 5'b00001);
      if (a < 32'h0020_0000) return 5'b00001;
      if (a >= 32'h0030_0000 && a < 32'h0040_0000) return 5'b00100;
      if (a >= 32'h1000_0000 && a < 32'h2000_0000) return 5'b00010;
      if (a >= 32'hF000_0000) return 5'b01000;
      return 5'b10000;
   endfunction

   task automatic chk(input int p, input logic [NS-1:0] exp, input string tag);
      logic [NS-1:0] got;
      got = sel[p*NS +: NS];
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s port %0d: got %b expected %b", tag, p, got, exp);
      end
   endtask

   // drive one address per port, then check all ports against the model
   task automatic probe(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [AW-1:0] a2, input string tag);
      @(negedge clk);
      vld = '1;
      addr = {a2, a1, a0};
      #1;
      chk(0, model(a0), tag);
      chk(1, model(a1), tag);
      chk(2, model(a2), tag);
   endtask

   task automatic do_reset(input bit b);
      @(negedge clk);
      rst_n = 1'b0;
      boot_ext = b;
      vld = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      boot_m = b;
      remap_m = 1'b0;
   endtask

   task automatic pulse(input bit s, input bit c);
      @(negedge clk);
      rset = s;
      rclr = c;
      @(negedge clk);
      rset = 1'b0;
      rclr = 1'b0;
      if (c) remap_m = 1'b0;
      else if (s) remap_m = 1'b1;
   endtask

   task automatic t_idle_after_reset;
      @(negedge clk);
      vld = '0;
      addr = {32'h0000_0000, 32'h0030_0000, 32'h8000_0000};
      #1;
      for (int p = 0; p < NP; p++) chk(p, 5'b00000, "R8 reset/idle");
   endtask

   task automatic t_boot_rom;
      probe(32'h0000_0000, 32'h000F_FFFF, 32'h0008_0000, "R2 R9 boot rom");
   endtask

   task automatic t_fixed(input string tag);
      probe(32'h0010_0000, 32'h0030_0004, 32'h1234_5678, tag);
      probe(32'hF000_0000, 32'h001F_FFFF, 32'h1FFF_FFFF, tag);
   endtask

   task automatic t_unmapped;
      probe(32'h0020_0000, 32'h8000_0000, 32'h0040_0000, "R7 unmapped");
   endtask

   task automatic t_pin_ignored;
      @(negedge clk);
      boot_ext = ~boot_m;
      repeat (5) @(negedge clk);
      probe(32'h0000_0100, 32'h0000_0000, 32'h000F_FFFC, "R1 pin ignored");
   endtask

   task automatic t_remap;
      pulse(1'b1, 1'b0);
      probe(32'h0000_0000, 32'h0004_0000, 32'h000F_FFFF, "R4 remap sram");
      repeat (4) @(negedge clk);
      probe(32'h0000_0010, 32'h0000_0000, 32'h000A_0000, "R4 remap held");
      t_fixed("R6 fixed under remap");
   endtask

   task automatic t_clear;
      pulse(1'b0, 1'b1);
      probe(32'h0000_0000, 32'h000F_FFFF, 32'h0001_0000, "R5 clear");
      pulse(1'b1, 1'b0);
      pulse(1'b1, 1'b1);
      probe(32'h0000_0000, 32'h0000_0004, 32'h0000_0008, "R5 clear wins");
   endtask

   task automatic t_valid_low;
      @(negedge clk);
      vld = 3'b010;
      addr = {32'hF000_0000, 32'h0000_0000, 32'h1000_0000};
      #1;
      chk(0, 5'b00000, "R8 valid low");
      chk(1, model(32'h0000_0000), "R8 valid high");
      chk(2, 5'b00000, "R8 valid low");
   endtask

   initial begin : main
      do_reset(1'b0);
      t_idle_after_reset();
      t_boot_rom();
      t_fixed("R6 fixed");
      t_unmapped();
      t_pin_ignored();
      t_remap();
      t_clear();
      t_valid_low();
      do_reset(1'b1);
      probe(32'h0000_0000, 32'h000F_FFFF, 32'h0010_0000, "R3 ext boot");
      t_pin_ignored();
      pulse(1'b1, 1'b0);
      probe(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, "R4 remap ext");
      do_reset(1'b1);
      probe(32'h0000_0000, 32'h0008_0000, 32'h000F_FFFF, "R10 reset clears remap");
      pulse(1'b0, 1'b1);
      probe(32'h0000_0000, 32'h0030_0000, 32'h2000_0000, "R5 R7 clear idle");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : watchdog
      #(2_000_000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule